// File: doc/BRIEF.md
# Fully Associative Write-Back Cache Controller

This block is a small cache placed between a byte-wide load/store port and a block-wide memory port. Any block may sit in any of its lines, so every lookup compares the request tag against all lines at once. With the default parameters it holds four lines of two bytes, for 8 bytes in all, behind a 16-bit byte address.

A request is held on the CPU side until the block answers with a one-cycle `cpu_ready` pulse. A hit answers from the array with no memory traffic. A miss picks a line. A free line is used first. When no line is free, the least recently used line is taken. If that victim holds modified data, it is written back first. The whole aligned block is then read, and the lookup is retried. Stores are kept in the cache and reach memory only when their line is evicted. Replacement order is kept as a per-line recency rank. Rank 0 is the most recent line, and the line at the highest rank is the victim.

Top module: `fac_cache`

## Requirements
- R1: The tag is `cpu_addr[15:1]` and the offset is `cpu_addr[0]`. Within a block, offset 0 is bits [7:0] and offset 1 is bits [15:8]. A load returns the addressed byte on `cpu_rdata`.
- R2: A miss issues a read with `mem_baddr` equal to the request tag. The read brings in both bytes of the aligned block, so a later access to the other byte of that block hits.
- R3: With each response, `cpu_hit` reports whether the block was already present. A hit completes with no memory request.
- R4: While any line is invalid, a miss never evicts or writes back a valid line.
- R5: When all lines are valid, a miss replaces the least recently used block. Each hit or fill makes the accessed line the most recent one.
- R6: A store sets the line's dirty flag, and a refill clears it. Evicting a clean line issues no memory write.
- R7: Evicting a dirty line issues one memory write (`mem_we`=1) of its tag and full block data. The refill read of the new block follows it.
- R8: A store miss reads the block, merges the byte into the cache, and does not write to memory.
- R9: `mem_req` stays high until `mem_ack`. `cpu_ready` is a single-cycle pulse, given only after any write-back and refill have completed.
- R10: After reset, all lines are invalid and neither `cpu_ready` nor `mem_req` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Access request, held until cpu_ready |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Access hit, valid with cpu_ready |
| cpu_rdata | output | 8 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_baddr | output | 15 | Block address (byte address / 2) |
| mem_wdata | output | 16 | Write-back block data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | 16 | Refill block data, valid with mem_ack |

## Verification
A corrupted recency rank, dirty flag or valid flag does not show at once. It appears at the next eviction, as a write-back of the wrong block, a missing or extra memory write, or a miss where a hit was due. The bench therefore uses a 12-block address range that forces replacements every few accesses, so such faults surface within a handful of requests. A wrong byte merge or byte select appears on the next load of that byte, or in the data of a later write-back.

// File: rtl/fac_pkg.sv
package fac_pkg;

  // controller phases of one access
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WBACK,
    ST_FILL,
    ST_RESP
  } fac_state_e;

endpackage

// File: rtl/fac_rst_sync.sv
module fac_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/fac_match.sv
module fac_match #(
  parameter  int LINES = 4,
  parameter  int TAG_W = 15,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             valid    [LINES],
  input  logic [TAG_W-1:0] tags     [LINES],
  input  logic [TAG_W-1:0] look_tag,
  output logic [LINES-1:0] hit_vec,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             has_free,
  output logic [IDX_W-1:0] free_idx
);

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == look_tag);
  end

  // descending scan: the lowest matching / free line wins
  always_comb begin
    hit      = |hit_vec;
    hit_idx  = '0;
    has_free = 1'b0;
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (!valid[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/fac_lru.sv
module fac_lru #(
  parameter  int LINES  = 4,
  localparam int RANK_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch,
  input  logic [RANK_W-1:0] touch_idx,
  output logic [RANK_W-1:0] victim_idx
);

  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(LINES - 1);

  logic [RANK_W-1:0] rank_q [LINES];
  logic [RANK_W-1:0] rank_d [LINES];
  logic [LINES-1:0]  oldest_vec;

  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      rank_d[i] = rank_q[i];
      if (touch) begin
        if (RANK_W'(i) == touch_idx)               rank_d[i] = '0;
        else if (rank_q[i] < rank_q[touch_idx])    rank_d[i] = rank_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) rank_q[i] <= RANK_W'(i);
    end else if (touch) begin
      for (int i = 0; i < LINES; i++) rank_q[i] <= rank_d[i];
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      oldest_vec[i] = (rank_q[i] == OLDEST);
      if (oldest_vec[i]) victim_idx = RANK_W'(i);
    end
  end

  // R5
  rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  // R5
  touch_newest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> rank_q[$past(touch_idx)] == '0);

endmodule

// File: rtl/fac_cache.sv
module fac_cache
  import fac_pkg::*;
#(
  parameter  int ADDR_W      = 16,
  parameter  int BLOCK_BYTES = 2,
  parameter  int LINES       = 4,
  localparam int OFF_W       = $clog2(BLOCK_BYTES),
  localparam int TAG_W       = ADDR_W - OFF_W,
  localparam int BLK_W       = 8 * BLOCK_BYTES,
  localparam int IDX_W       = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic [7:0]        cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [TAG_W-1:0]  mem_baddr,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [BLK_W-1:0]  mem_rdata
);

  logic rst_ns;

  fac_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  fac_state_e state_q, state_d;

  logic [TAG_W-1:0] req_tag_q;
  logic [OFF_W-1:0] req_off_q;
  logic             req_we_q;
  logic [7:0]       req_wdata_q;
  logic             miss_q;
  logic [IDX_W-1:0] vic_q, vic_d;
  logic [7:0]       rdata_q, rdata_d;

  logic             valid_q [LINES];
  logic             dirty_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];
  logic [BLK_W-1:0] data_q  [LINES];

  logic             cap_en, touch, look_wr, fill_en, miss_set, vic_en, rdata_en;
  logic [LINES-1:0] hit_vec;
  logic             hit, has_free;
  logic [IDX_W-1:0] hit_idx, free_idx, lru_idx;

  fac_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
    .valid    (valid_q),
    .tags     (tag_q),
    .look_tag (req_tag_q),
    .hit_vec  (hit_vec),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .has_free (has_free),
    .free_idx (free_idx)
  );

  fac_lru #(.LINES(LINES)) u_lru (
    .clk        (clk),
    .rst_n      (rst_ns),
    .touch      (touch),
    .touch_idx  (hit_idx),
    .victim_idx (lru_idx)
  );

  // next-state and control
  always_comb begin
    state_d  = state_q;
    cap_en   = 1'b0;
    touch    = 1'b0;
    look_wr  = 1'b0;
    fill_en  = 1'b0;
    miss_set = 1'b0;
    vic_en   = 1'b0;
    vic_d    = vic_q;
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          cap_en  = 1'b1;
          state_d = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (hit) begin
          touch    = 1'b1;
          rdata_en = 1'b1;
          rdata_d  = data_q[hit_idx][int'(req_off_q)*8 +: 8];
          look_wr  = req_we_q;
          state_d  = ST_RESP;
        end else begin
          miss_set = 1'b1;
          vic_en   = 1'b1;
          vic_d    = has_free ? free_idx : lru_idx;
          state_d  = (!has_free && dirty_q[lru_idx]) ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: if (mem_ack) state_d = ST_FILL;
      ST_FILL: begin
        if (mem_ack) begin
          fill_en = 1'b1;
          state_d = ST_LOOK;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_en)        miss_q <= 1'b0;
      else if (miss_set) miss_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      req_tag_q   <= cpu_addr[ADDR_W-1:OFF_W];
      req_off_q   <= cpu_addr[OFF_W-1:0];
      req_we_q    <= cpu_write;
      req_wdata_q <= cpu_wdata;
    end
    if (vic_en)   vic_q   <= vic_d;
    if (rdata_en) rdata_q <= rdata_d;
  end

  // line storage
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel_fill, sel_wr;
    assign sel_fill = fill_en && (vic_q == IDX_W'(g));
    assign sel_wr   = look_wr && (hit_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (sel_fill) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= 1'b0;
      end else if (sel_wr) begin
        dirty_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_fill) begin
        tag_q[g]  <= req_tag_q;
        data_q[g] <= mem_rdata;
      end else if (sel_wr) begin
        data_q[g][int'(req_off_q)*8 +: 8] <= req_wdata_q;
      end
    end
  end

  assign cpu_ready = (state_q == ST_RESP);
  assign cpu_hit   = cpu_ready && !miss_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_baddr = mem_we ? tag_q[vic_q] : req_tag_q;
  assign mem_wdata = data_q[vic_q];

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_req && !mem_ack) |=> mem_req);

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cpu_ready |=> !cpu_ready);

  // R7
  wb_dirty_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_we |-> (valid_q[vic_q] && dirty_q[vic_q]));

  // R7
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_we && mem_ack) |=> (mem_req && !mem_we));

  // R4
  free_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (state_q == ST_LOOK && !hit && has_free) |=> !mem_we);

  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(hit_vec));

endmodule

// File: tb/fac_cache_tb.sv
module fac_cache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_LAT    = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_valid, cpu_write;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_ready, cpu_hit;
  logic [7:0]  cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [14:0] mem_baddr;
  logic [15:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fac_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
    .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_baddr(mem_baddr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  typedef struct { bit we; logic [14:0] baddr; logic [15:0] data; string req; } mem_op_t;
  typedef struct { bit is_st; bit hit; logic [7:0] rdata; logic [15:0] addr; string req; } resp_t;

  mem_op_t exp_mem[$];
  resp_t   exp_rsp[$];

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] mem_b [int];   // memory seen by the design
  logic [7:0] sh_b  [int];   // shadow used by the reference model

  function automatic logic [7:0] init_byte(int a);
    logic [15:0] x = a[15:0];
    return (x[7:0] * 8'd7) ^ x[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] rd_mem(int a);
    return mem_b.exists(a) ? mem_b[a] : init_byte(a);
  endfunction

  function automatic logic [7:0] rd_sh(int a);
    return sh_b.exists(a) ? sh_b[a] : init_byte(a);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  bit          m_valid [4];
  bit          m_dirty [4];
  logic [14:0] m_tag   [4];
  logic [15:0] m_data  [4];
  int          m_rank  [4];

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 0; m_dirty[i] = 0; m_rank[i] = i;
    end
  endtask

  // driver: predicts, queues expectations, drives one access
  task automatic access(bit we, logic [15:0] a, logic [7:0] d, string req);
    logic [14:0] t = a[15:1];
    int idx = -1;
    bit h;
    resp_t r;
    for (int i = 0; i < 4; i++) if (m_valid[i] && m_tag[i] == t) idx = i;
    h = (idx >= 0);
    if (!h) begin
      for (int i = 3; i >= 0; i--) if (!m_valid[i]) idx = i;
      if (idx < 0) for (int i = 0; i < 4; i++) if (m_rank[i] == 3) idx = i;
      if (m_valid[idx] && m_dirty[idx]) begin
        exp_mem.push_back('{1'b1, m_tag[idx], m_data[idx], "R7"});
        sh_b[{m_tag[idx], 1'b0}] = m_data[idx][7:0];
        sh_b[{m_tag[idx], 1'b1}] = m_data[idx][15:8];
      end
      exp_mem.push_back('{1'b0, t, 16'h0, "R2"});
      m_data[idx]  = {rd_sh({t, 1'b1}), rd_sh({t, 1'b0})};
      m_tag[idx]   = t;
      m_valid[idx] = 1;
      m_dirty[idx] = 0;
    end
    for (int i = 0; i < 4; i++) if (i != idx && m_rank[i] < m_rank[idx]) m_rank[i]++;
    m_rank[idx] = 0;
    r.is_st = we; r.hit = h; r.addr = a; r.req = req;
    r.rdata = a[0] ? m_data[idx][15:8] : m_data[idx][7:0];
    if (we) begin
      if (a[0]) m_data[idx][15:8] = d; else m_data[idx][7:0] = d;
      m_dirty[idx] = 1;
    end
    exp_rsp.push_back(r);
    @(negedge clk);
    cpu_valid = 1; cpu_write = we; cpu_addr = a; cpu_wdata = d;
    do @(negedge clk); while (!cpu_ready);
    cpu_valid = 0;
  endtask

  // memory model and checker of memory traffic
  initial begin
    mem_ack = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (mem_req) begin
        mem_op_t e;
        repeat (MEM_LAT) @(negedge clk);
        if (exp_mem.size() == 0) begin
          check(0, "R3/R6/R8", "unexpected memory request we/baddr", {mem_we, mem_baddr}, 0);
        end else begin
          e = exp_mem.pop_front();
          check(mem_we == e.we, e.req, "request kind (R7 order)", mem_we, e.we);
          check(mem_baddr == e.baddr, e.req, "block address", mem_baddr, e.baddr);
          if (e.we) check(mem_wdata == e.data, "R7", "write-back data", mem_wdata, e.data);
        end
        if (mem_we) begin
          mem_b[{mem_baddr, 1'b0}] = mem_wdata[7:0];
          mem_b[{mem_baddr, 1'b1}] = mem_wdata[15:8];
        end else begin
          mem_rdata = {rd_mem({mem_baddr, 1'b1}), rd_mem({mem_baddr, 1'b0})};
        end
        mem_ack = 1;
      end
    end
  end

  // monitor: pops and compares responses
  initial begin
    bit prev_rdy = 0;
    forever begin
      @(negedge clk);
      if (cpu_ready) begin
        resp_t r;
        check(!prev_rdy, "R9", "ready longer than one cycle", 1, 0);
        if (exp_rsp.size() == 0) begin
          check(0, "R9", "unexpected response", 1, 0);
        end else begin
          r = exp_rsp.pop_front();
          check(cpu_hit == r.hit, {r.req, "/R3"}, $sformatf("hit flag @%0h", r.addr), cpu_hit, r.hit);
          if (!r.is_st)
            check(cpu_rdata == r.rdata, {r.req, "/R1"}, $sformatf("load data @%0h", r.addr), cpu_rdata, r.rdata);
        end
      end
      prev_rdy = cpu_ready;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    cpu_valid = 0; cpu_write = 0; cpu_addr = '0; cpu_wdata = '0;
    model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R10: idle outputs during reset
    check(cpu_ready == 0, "R10", "ready in reset", cpu_ready, 0);
    check(mem_req == 0, "R10", "mem_req in reset", mem_req, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(cpu_ready == 0 && mem_req == 0, "R10", "idle after reset", {cpu_ready, mem_req}, 0);

    // R2, R10: block fetch and neighbour hit
    access(0, 16'h0001, 8'h00, "R10");
    access(0, 16'h0005, 8'h00, "R2");
    access(0, 16'h0001, 8'h00, "R3");
    access(0, 16'h0004, 8'h00, "R2");
    // R8: store miss allocates, no write-through
    access(1, 16'h0100, 8'h11, "R8");
    access(0, 16'h0100, 8'h00, "R8");
    access(0, 16'h0101, 8'h00, "R1");
    // R4: last free line used
    access(0, 16'h0200, 8'h00, "R4");
    // R5/R6: LRU block 0 is clean, replaced with no write
    access(0, 16'h0300, 8'h00, "R5");
    access(0, 16'h0001, 8'h00, "R6");
    // R7: dirty block 0x80 is the victim
    access(1, 16'h0401, 8'h22, "R7");
    access(0, 16'h0100, 8'h00, "R7");
    access(0, 16'h0401, 8'h00, "R6");

    // mixed traffic over 12 blocks
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(lfsr[0], 16'((lfsr[7:4] % 12) * 2) + 16'(lfsr[1]), lfsr[15:8], "R5");
    end

    repeat (MEM_LAT + 4) @(negedge clk);
    check(exp_mem.size() == 0, "R9", "pending memory operations", exp_mem.size(), 0);
    check(exp_rsp.size() == 0, "R9", "pending responses", exp_rsp.size(), 0);
    finish_run();
  end

endmodule